// File: doc/BRIEF.md
# Filtered Edge Pin Interrupt Controller

This block watches the eight pads of a general-purpose I/O port and raises one shared interrupt request when a selected edge appears on a pin whose interrupt is enabled. The block always works from the level it senses on the pad, so a pin that the port drives as an output can still raise interrupts. Every pad passes through a two-flop synchroniser and then a digital pulse filter. The filter accepts a new level only after that level has stayed unchanged for a programmed number of filter ticks. If the level goes back before then, the count starts again. An accepted change that matches the pin's chosen polarity sets a sticky flag for that pin. Software clears a flag by writing a one to it.

Software sets up the block over a small register bus. The bus writes on the clock and reads combinationally. It holds a per-pin enable, a per-pin edge polarity, the flags, one filter length shared by all pins, and a view of the filtered levels. The interrupt request is asserted while any pin has both its flag and its enable set. `clk` is the block's always-on clock. While `stop_mode` is high, the filter advances only on rising edges of the slow low-power clock `lp_clk`, which the block synchronises itself. In that state the `wake` output follows the same flag-and-enable condition, so a filtered pin event can bring the system out of stop or wait.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, all enables are 0, all polarities are 0 (falling edge), all flags are 0, the filter length is 0, and `irq` and `wake` are low.
- R2: Each pin's flag sets on a qualifying edge whatever its enable bit is. Pin n adds to `irq` only while its enable bit n (register 0) is 1.
- R3: Polarity bit n (register 1) chooses the edge for pin n: 1 means a rising edge (filtered level goes 0 to 1) and 0 means a falling edge. An edge of the other direction leaves the flag unchanged.
- R4: `irq` is high exactly when some pin has its flag bit (register 2) and its enable bit both at 1.
- R5: Let L be the filter length in bits [3:0] of register 3. A pad change is accepted only after the synchronised level has differed from the filtered level for L+1 consecutive filter ticks. A shorter pulse sets no flag.
- R6: If the synchronised level returns to the filtered level before acceptance, the count restarts. Two runs, each shorter than L+1 ticks and separated by a reversion, set no flag.
- R7: Writing to register 2 clears each flag whose write-data bit is 1. Flags whose bit is 0 stay as they are.
- R8: If a flag's qualifying edge is accepted in the same cycle that a clear is written for that flag, the flag stays set.
- R9: While `stop_mode` is 1, filter ticks come only from rising edges of `lp_clk`. `wake` is high exactly when `stop_mode` is 1 and some pin has its flag and enable both set.
- R10: Register 4 reads back the filtered level of each pin. While `stop_mode` is 0 there is one filter tick per `clk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | Low-power state: filter ticks come from `lp_clk`, wake enabled |
| lp_clk | input | 1 | Free-running slow low-power clock |
| pad_in | input | 8 | Sensed pad levels |
| bus_addr | input | 3 | Register index: 0 enable, 1 polarity, 2 flags, 3 filter length, 4 filtered level |
| bus_wr | input | 1 | Write strobe, acts on the rising edge of `clk` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake request while in stop mode |

## Verification
An accepted edge and a software write-one-to-clear can land on the same flag in the same clock cycle. The bench first sets the filter length to zero, which makes acceptance happen exactly three clock edges after the pad changes. It then times the clear write so that it takes effect on that third edge. The flag must read 1 afterwards. A second clear with no edge pending must then remove the flag, which shows that the clear path itself works.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int NPINS = 8;
    localparam int FLT_W = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
    localparam logic [ADDR_W-1:0] A_POLAR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd4;

    typedef struct packed {
        logic [NPINS-1:0] enable;
        logic [NPINS-1:0] rising;
        logic [NPINS-1:0] flag;
        logic [FLT_W-1:0] flen;
    } pin_regs_t;

    function automatic logic [NPINS-1:0] next_flags(
        input logic [NPINS-1:0] cur,
        input logic [NPINS-1:0] clr,
        input logic [NPINS-1:0] evt
    );
        return (cur & ~clr) | evt;
    endfunction

endpackage

// File: rtl/pin_irq_tick.sv
module pin_irq_tick (
    input  logic clk,
    input  logic rst,
    input  logic stop_mode,
    input  logic lp_clk,
    output logic tick
);
    logic [2:0] lp_sync;

    always_ff @(posedge clk) begin
        if (rst) lp_sync <= '0;
        else     lp_sync <= {lp_sync[1:0], lp_clk};
    end

    always_comb begin
        if (stop_mode) tick = lp_sync[1] & ~lp_sync[2];
        else           tick = 1'b1;
    end
endmodule

// File: rtl/pin_irq_filter.sv
module pin_irq_filter #(
    parameter int CW = pin_irq_pkg::FLT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          raw,
    input  logic [CW-1:0] len,
    output logic          level,
    output logic          accept
);
    logic [1:0]    sync;
    logic [CW-1:0] cnt;
    logic          differs;

    always_comb begin
        differs = sync[1] != level;
        accept  = differs && tick && (cnt >= len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= '0;
            cnt   <= '0;
            level <= 1'b0;
        end else begin
            sync <= {sync[0], raw};
            if (!differs) begin
                cnt <= '0;
            end else if (accept) begin
                level <= sync[1];
                cnt   <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  evt,
    input  logic [NPINS-1:0]  level,
    output pin_regs_t         regs,
    output logic [NPINS-1:0]  bus_rdata
);
    logic [NPINS-1:0] clr;

    always_comb begin
        clr = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            regs.flag <= next_flags(regs.flag, clr, evt);
            if (bus_wr) begin
                case (bus_addr)
                    A_ENABLE: regs.enable <= bus_wdata;
                    A_POLAR:  regs.rising <= bus_wdata;
                    A_FLEN:   regs.flen   <= bus_wdata[FLT_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            A_ENABLE: bus_rdata = regs.enable;
            A_POLAR:  bus_rdata = regs.rising;
            A_FLAGS:  bus_rdata = regs.flag;
            A_FLEN:   bus_rdata = {{(NPINS-FLT_W){1'b0}}, regs.flen};
            A_LEVEL:  bus_rdata = level;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pin_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_mode,
    input  logic              lp_clk,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq,
    output logic              wake
);
    logic             tick;
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] accept;
    logic [NPINS-1:0] evt;
    pin_regs_t        regs;

    pin_irq_tick u_tick (
        .clk(clk), .rst(rst), .stop_mode(stop_mode),
        .lp_clk(lp_clk), .tick(tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_irq_filter #(.CW(FLT_W)) u_filt (
            .clk(clk), .rst(rst), .tick(tick), .raw(pad_in[i]),
            .len(regs.flen), .level(level[i]), .accept(accept[i])
        );
        // new level equals the chosen polarity: 1 for rising, 0 for falling
        assign evt[i] = accept[i] && (~level[i] == regs.rising[i]);
    end

    pin_irq_regs u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .evt(evt), .level(level),
        .regs(regs), .bus_rdata(bus_rdata)
    );

    always_comb begin
        irq  = |(regs.flag & regs.enable);
        wake = stop_mode & irq;
    end
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
    parameter int N = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          stop_mode,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [N-1:0]  bus_wdata,
    input logic          irq,
    input logic          wake,
    input logic [N-1:0]  flags,
    input logic [N-1:0]  enables,
    input logic [N-1:0]  level,
    input logic [N-1:0]  evt,
    input logic          tick
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && enables == '0));

    // R2
    flag_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~$past(flags)) & ~$past(evt)) == '0);

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd2) |=>
        ((flags & $past(bus_wdata) & ~$past(evt)) == '0));

    // R8
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd2 && (evt & bus_wdata) != '0) |=>
        ((flags & $past(evt & bus_wdata)) == $past(evt & bus_wdata)));

    // R5
    level_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(level));

    // R9
    wake_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> (stop_mode && irq));

    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 3'd0) |=> $stable(enables));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.N(pin_irq_pkg::NPINS), .AW(pin_irq_pkg::ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .stop_mode(stop_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq(irq), .wake(wake),
    .flags(regs.flag), .enables(regs.enable), .level(level), .evt(evt),
    .tick(tick)
);

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       lp_clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_mode = 1'b0;
    logic [7:0] pad_in = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, wake;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    pin_irq_ctrl uut (
        .clk(clk), .rst(rst), .stop_mode(stop_mode), .lp_clk(lp_clk),
        .pad_in(pad_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    always #5 clk = ~clk;
    always #40 lp_clk = ~lp_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int pin, input int w);
        pad_in[pin] = 1'b1;
        idle(w);
        pad_in[pin] = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd0, d); chk("R1 enable", d, 8'h00);
        rd(3'd1, d); chk("R1 polarity", d, 8'h00);
        rd(3'd2, d); chk("R1 flags", d, 8'h00);
        rd(3'd3, d); chk("R1 flen", d, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 wake", wake, 1'b0);
    endtask

    task automatic t_filter();
        logic [7:0] d;
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h03);
        pulse(0, 3); idle(12);
        rd(3'd2, d); chk("R5 short pulse rejected", d[0], 1'b0);
        pulse(0, 4); idle(12);
        rd(3'd2, d); chk("R5 long pulse accepted", d[0], 1'b1);
        chk("R4 irq from pin0", irq, 1'b1);
        wr(3'd2, 8'h01);
        chk("R4 irq after clear", irq, 1'b0);
    endtask

    task automatic t_restart();
        logic [7:0] d;
        pulse(1, 3); idle(1);
        pulse(1, 3); idle(12);
        rd(3'd2, d); chk("R6 broken run rejected", d[1], 1'b0);
        rd(3'd4, d); chk("R6 level stayed low", d[1], 1'b0);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h08);
        wr(3'd0, 8'h0C);
        pad_in[2] = 1'b1; pad_in[3] = 1'b1; idle(8);
        rd(3'd2, d); chk("R3 rising on falling-pol pin2", d[2], 1'b0);
        chk("R3 rising on rising-pol pin3", d[3], 1'b1);
        rd(3'd4, d); chk("R10 level reads high", d[3:2], 2'b11);
        pad_in[2] = 1'b0; pad_in[3] = 1'b0; idle(8);
        rd(3'd2, d); chk("R3 falling on pin2", d[2], 1'b1);
        rd(3'd4, d); chk("R10 level reads low", d[3:2], 2'b00);
        wr(3'd2, 8'h0C);
        rd(3'd2, d); chk("R7 clear pins 2,3", d, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr(3'd1, 8'h10);
        wr(3'd0, 8'h00);
        pulse(4, 3); idle(8);
        rd(3'd2, d); chk("R2 flag sets while disabled", d[4], 1'b1);
        chk("R2 irq low while disabled", irq, 1'b0);
        wr(3'd0, 8'h10);
        chk("R2 irq after enable", irq, 1'b1);
        wr(3'd2, 8'h00);
        rd(3'd2, d); chk("R7 zero write keeps flag", d[4], 1'b1);
        wr(3'd2, 8'h10);
        rd(3'd2, d); chk("R7 one write clears flag", d[4], 1'b0);
        chk("R4 irq low after clear", irq, 1'b0);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h40);
        pad_in[6] = 1'b1; idle(8);
        pad_in[6] = 1'b0; idle(8);
        rd(3'd2, d); chk("R3 falling sets pin6", d[6], 1'b1);
        pad_in[6] = 1'b1; idle(8);
        rd(3'd2, d); chk("R8 flag set before collision", d[6], 1'b1);
        pad_in[6] = 1'b0;
        idle(2);
        wr(3'd2, 8'h40);
        rd(3'd2, d); chk("R8 edge beats clear", d[6], 1'b1);
        wr(3'd2, 8'h40);
        rd(3'd2, d); chk("R8 later clear works", d[6], 1'b0);
    endtask

    task automatic t_stop();
        logic [7:0] d;
        wr(3'd3, 8'h02);
        wr(3'd1, 8'h20);
        wr(3'd0, 8'h20);
        stop_mode = 1'b1;
        idle(4);
        pulse(5, 6); idle(40);
        rd(3'd2, d); chk("R9 short pulse in stop rejected", d[5], 1'b0);
        chk("R9 no wake", wake, 1'b0);
        pad_in[5] = 1'b1; idle(60);
        rd(3'd2, d); chk("R9 long pulse in stop accepted", d[5], 1'b1);
        chk("R9 wake high", wake, 1'b1);
        chk("R9 irq high", irq, 1'b1);
        stop_mode = 1'b0; #1;
        chk("R9 wake drops outside stop", wake, 1'b0);
        chk("R9 irq stays", irq, 1'b1);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_filter();
        t_restart();
        t_polarity();
        t_enable();
        t_collision();
        t_stop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule